// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Mode

A single timer channel behind a small 32-bit register bus. The bus clock is first divided by a 16-bit prescaler. The divided tick then decrements a 16-bit period counter. When the period runs out, the timer has expired. An expiry sets an interrupt flag. The timer then either stops (one-shot) or reloads and runs again (continuous). In continuous mode, a new count written during a run is applied only at the next reload, so the period in progress is never cut short.

The same channel can serve as a watchdog. Software sets the watchdog bit together with the run bit and then refreshes the timer by writing a fixed key byte into the top byte of the mode word. If no valid refresh arrives before the count expires, a one-cycle reset pulse is emitted and the counter halts. Once armed, the watchdog cannot be stopped by clearing the run bit alone. Software has to clear the watchdog bit itself.

Word addresses: 0 is the mode register, 1 is the count register, 2 is the status register.

Top module: `ptmr_top`

## Requirements
- R1: After reset the mode, count and status registers all read 0, and `irq` and `wdt_reset` are low.
- R2: The count register holds the prescaler value P in bits 31:16 and the period value N in bits 15:0. Writing mode bit 12 (run) from 0 to 1 starts the timer, and the expiry takes effect P*N clock edges after the starting write.
- R3: A prescaler field of 0 divides by 65536, and a period field of 0 counts 65536 ticks.
- R4: When mode bit 10 (continuous) is clear, an expiry clears mode bit 12, and no further expiry follows.
- R5: When mode bit 10 is set, the timer reloads at each expiry and keeps running. A count written while the timer runs is used from the next reload onward.
- R6: Each expiry sets status bit 0. `irq` is high exactly when any status bit 3:0 is set and mode bit 8 (interrupt enable) is set.
- R7: Writing ones to status bits 3:0 (byte 0) clears those flags. Writing zeros leaves them unchanged.
- R8: While mode bit 15 (watchdog) is set, mode bit 8 reads 0 and `irq` stays low.
- R9: In watchdog mode with the timer running, a write of 0xA5 to bits 31:24 of the mode register restarts the count from the count register. Any other byte value, or the same write outside watchdog mode, leaves the running count unchanged.
- R10: A watchdog expiry drives `wdt_reset` high for exactly one clock cycle, clears mode bit 12, and leaves mode bit 15 set.
- R11: In watchdog mode, a mode write that keeps bit 15 set cannot clear bit 12. A write that clears bit 15 leaves watchdog mode.
- R12: Clearing mode bit 12 outside watchdog mode stops counting, and no expiry occurs afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is zero when low |
| bus_addr | input | 2 | Word address: 0 mode, 1 count, 2 status |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq | output | 1 | Interrupt request |
| wdt_reset | output | 1 | One-cycle reset pulse on watchdog expiry |

## Verification
The bench uses the default parameters: a 16-bit prescaler, a 16-bit period, four status flags and a two-bit word address. With the fields at full width, both encodings of zero (a prescaler of 0 and a period of 0) are run to their 65536-cycle expiry edge in the same run. Every expiry is sampled one cycle before and on the exact edge that P*N predicts. This exposes off-by-one faults in the prescaler and in the period counter, a refresh that accepts the wrong key, and a reset pulse longer than one cycle.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  // Bit positions inside the mode word (all within byte 1)
  localparam int MODE_IE_BIT   = 8;
  localparam int MODE_CONT_BIT = 10;
  localparam int MODE_RUN_BIT  = 12;
  localparam int MODE_WDOG_BIT = 15;

  // Refresh key written into the top byte of the mode word
  localparam logic [7:0] WDOG_KEY = 8'hA5;

  typedef struct packed {
    logic wdog;
    logic run;
    logic cont;
    logic ie;
  } mode_t;

endpackage

// File: rtl/ptmr_downcnt.sv
module ptmr_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] rel_val,
  output logic         term
);

  localparam int VW = W + 1;

  logic [VW-1:0] val_q;
  logic [VW-1:0] val_d;
  logic          at_one;

  // A field of zero stands for 2**W
  function automatic logic [VW-1:0] expand(input logic [W-1:0] x);
    return {(x == '0), x};
  endfunction

  assign at_one = (val_q == VW'(1));
  assign term   = step & at_one;

  always_comb begin
    val_d = val_q;
    if (load) begin
      val_d = expand(load_val);
    end else if (step) begin
      val_d = at_one ? expand(rel_val) : (val_q - VW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= VW'(1);
    end else begin
      val_q <= val_d;
    end
  end

  // R3
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    val_q != '0);

endmodule

// File: rtl/ptmr_engine.sv
module ptmr_engine #(
  parameter int PRESC_W  = 16,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                load,
  input  logic [PRESC_W-1:0]  presc_in,
  input  logic [PERIOD_W-1:0] period_in,
  output logic                expire
);

  logic [PRESC_W-1:0] sh_presc_q;
  logic [PRESC_W-1:0] sh_presc_d;
  logic               tick;
  logic               reload;

  // Both counters restart from the count register at start, refresh or expiry
  assign reload = load | expire;

  always_comb begin
    sh_presc_d = sh_presc_q;
    if (reload) begin
      sh_presc_d = presc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_presc_q <= '0;
    end else begin
      sh_presc_q <= sh_presc_d;
    end
  end

  ptmr_downcnt #(.W(PRESC_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .step     (run),
    .load_val (presc_in),
    .rel_val  (sh_presc_q),
    .term     (tick)
  );

  ptmr_downcnt #(.W(PERIOD_W)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reload),
    .step     (tick),
    .load_val (period_in),
    .rel_val  (period_in),
    .term     (expire)
  );

endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int PRESC_W  = 16,
  parameter int PERIOD_W = 16,
  parameter int FLAG_W   = 4,
  parameter int ADDR_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [(PRESC_W+PERIOD_W)/8-1:0] bus_be,
  input  logic [PRESC_W+PERIOD_W-1:0]  bus_wdata,
  output logic [PRESC_W+PERIOD_W-1:0]  bus_rdata,
  input  logic                         expire,
  output mode_t                        mode_o,
  output logic [PRESC_W-1:0]           presc_o,
  output logic [PERIOD_W-1:0]          period_o,
  output logic                         load_o,
  output logic [FLAG_W-1:0]            flags_o
);

  localparam int DW   = PRESC_W + PERIOD_W;
  localparam int BE_W = DW / 8;
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(2);

  mode_t             mode_q, mode_d;
  logic [DW-1:0]     count_q, count_d;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              wr_mode, wr_count, wr_stat;
  logic              start, refresh;
  logic [DW-1:0]     mode_rd;

  assign wr_mode  = bus_wr && (bus_addr == A_MODE);
  assign wr_count = bus_wr && (bus_addr == A_COUNT);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);

  // Mode register: hardware stop first, a bus write to byte 1 overrides it
  always_comb begin
    mode_d = mode_q;
    if (expire && (mode_q.wdog || !mode_q.cont)) begin
      mode_d.run = 1'b0;
    end
    if (wr_mode && bus_be[1]) begin
      mode_d.wdog = bus_wdata[MODE_WDOG_BIT];
      mode_d.cont = bus_wdata[MODE_CONT_BIT];
      mode_d.ie   = bus_wdata[MODE_IE_BIT] & ~bus_wdata[MODE_WDOG_BIT];
      mode_d.run  = bus_wdata[MODE_RUN_BIT] |
                    (mode_q.wdog & mode_q.run & bus_wdata[MODE_WDOG_BIT]);
    end
  end

  assign start   = wr_mode && bus_be[1] && mode_d.run && !mode_q.run;
  assign refresh = wr_mode && bus_be[BE_W-1] && mode_q.wdog && mode_q.run &&
                   (bus_wdata[DW-1 -: 8] == WDOG_KEY);
  assign load_o  = start | refresh;

  always_comb begin
    count_d = count_q;
    for (int b = 0; b < BE_W; b++) begin
      if (wr_count && bus_be[b]) begin
        count_d[8*b +: 8] = bus_wdata[8*b +: 8];
      end
    end
  end

  // Status flags: write-one-to-clear, a same-cycle expiry sets bit 0
  always_comb begin
    flags_d = flags_q;
    if (wr_stat && bus_be[0]) begin
      flags_d = flags_q & ~bus_wdata[FLAG_W-1:0];
    end
    if (expire) begin
      flags_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      count_q <= '0;
      flags_q <= '0;
    end else begin
      mode_q  <= mode_d;
      count_q <= count_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    mode_rd                = '0;
    mode_rd[MODE_WDOG_BIT] = mode_q.wdog;
    mode_rd[MODE_RUN_BIT]  = mode_q.run;
    mode_rd[MODE_CONT_BIT] = mode_q.cont;
    mode_rd[MODE_IE_BIT]   = mode_q.ie;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_MODE:  bus_rdata = mode_rd;
        A_COUNT: bus_rdata = count_q;
        A_STAT:  bus_rdata = DW'(flags_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign mode_o   = mode_q;
  assign presc_o  = count_q[PERIOD_W +: PRESC_W];
  assign period_o = count_q[PERIOD_W-1:0];
  assign flags_o  = flags_q;

  // R8
  wdog_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.wdog |-> !mode_q.ie);

  // R11
  wdog_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.wdog && mode_q.run && !expire &&
     !(wr_mode && bus_be[1] && !bus_wdata[MODE_WDOG_BIT])) |=> mode_q.run);

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flags_q[0]);

  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode_q.cont && !(wr_mode && bus_be[1])) |=> !mode_q.run);

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int PRESC_W  = 16,
  parameter int PERIOD_W = 16,
  parameter int FLAG_W   = 4,
  parameter int ADDR_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [(PRESC_W+PERIOD_W)/8-1:0] bus_be,
  input  logic [PRESC_W+PERIOD_W-1:0]     bus_wdata,
  output logic [PRESC_W+PERIOD_W-1:0]     bus_rdata,
  output logic                            irq,
  output logic                            wdt_reset
);

  logic [1:0]          rst_pipe_q;
  logic                rst_core_n;
  mode_t               mode;
  logic [PRESC_W-1:0]  presc;
  logic [PERIOD_W-1:0] period;
  logic                load;
  logic                expire;
  logic [FLAG_W-1:0]   flags;
  logic                wdt_q, wdt_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  ptmr_regs #(
    .PRESC_W  (PRESC_W),
    .PERIOD_W (PERIOD_W),
    .FLAG_W   (FLAG_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .expire    (expire),
    .mode_o    (mode),
    .presc_o   (presc),
    .period_o  (period),
    .load_o    (load),
    .flags_o   (flags)
  );

  ptmr_engine #(
    .PRESC_W  (PRESC_W),
    .PERIOD_W (PERIOD_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (mode.run),
    .load      (load),
    .presc_in  (presc),
    .period_in (period),
    .expire    (expire)
  );

  assign wdt_d = expire & mode.wdog;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wdt_q <= 1'b0;
    end else begin
      wdt_q <= wdt_d;
    end
  end

  assign wdt_reset = wdt_q;
  assign irq       = (|flags) & mode.ie;

  // R10
  wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    wdt_reset |=> !wdt_reset);

endmodule

// File: tb/ptmr_top_bench.sv
module ptmr_top_bench;

  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [1:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        wdt_reset;

  int n_chk  = 0;
  int n_fail = 0;

  ptmr_top u_ptmr_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .wdt_reset (wdt_reset)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Starts and ends just after a falling edge; consumes one rising edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr  = a;
    bus_wdata = d;
    bus_be    = be;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_be    = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1;
    d        = bus_rdata;
    bus_rd   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_stat(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(2'd2, v);
    chk(req, v, exp);
  endtask

  task automatic clear_flags();
    wr(2'd2, 32'h0000_000F, 4'b0001);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R1 mode", v, 32'h0);
    rd(2'd1, v); chk("R1 count", v, 32'h0);
    rd(2'd2, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 wdt_reset", {31'b0, wdt_reset}, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(2'd1, {16'd3, 16'd4}, 4'hF);
    rd(2'd1, v); chk("R2 count layout", v, 32'h0003_0004);
    wr(2'd0, 32'h0000_1100, 4'b0010);       // t=0
    idle(11);
    chk_stat("R2 before P*N", 32'h0);
    chk("R6 irq low before", {31'b0, irq}, 32'h0);
    idle(1);
    chk_stat("R2 at P*N", 32'h1);
    chk("R6 irq high", {31'b0, irq}, 32'h1);
    rd(2'd0, v); chk("R4 run cleared", v, 32'h0000_0100);
    wr(2'd2, 32'h0, 4'b0001);
    chk_stat("R7 zero write keeps flag", 32'h1);
    clear_flags();
    chk_stat("R7 flag cleared", 32'h0);
    chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
    idle(20);
    chk_stat("R4 no second expiry", 32'h0);
  endtask

  task automatic t_continuous();
    wr(2'd1, {16'd2, 16'd3}, 4'hF);
    wr(2'd0, 32'h0000_1500, 4'b0010);       // t=0
    idle(2);
    wr(2'd1, {16'd1, 16'd5}, 4'hF);         // t=3
    idle(2);
    chk_stat("R5 before first expiry", 32'h0);
    idle(1);                                 // t=6
    chk_stat("R5 first expiry with old count", 32'h1);
    clear_flags();                           // t=7
    idle(3);                                 // t=10
    chk_stat("R5 before reload expiry", 32'h0);
    idle(1);                                 // t=11
    chk_stat("R5 new count after reload", 32'h1);
    wr(2'd0, 32'h0000_0500, 4'b0010);       // t=12, stop
    clear_flags();
    idle(12);
    chk_stat("R12 stopped timer silent", 32'h0);
  endtask

  task automatic t_zero_fields();
    wr(2'd1, {16'd0, 16'd1}, 4'hF);
    wr(2'd0, 32'h0000_1000, 4'b0010);
    idle(65535);
    chk_stat("R3 prescaler zero before 65536", 32'h0);
    idle(1);
    chk_stat("R3 prescaler zero at 65536", 32'h1);
    chk("R6 irq masked by bit 8", {31'b0, irq}, 32'h0);
    clear_flags();
    wr(2'd1, {16'd1, 16'd0}, 4'hF);
    wr(2'd0, 32'h0000_1000, 4'b0010);
    idle(65535);
    chk_stat("R3 period zero before 65536", 32'h0);
    idle(1);
    chk_stat("R3 period zero at 65536", 32'h1);
    clear_flags();
  endtask

  task automatic t_key_outside();
    wr(2'd1, {16'd1, 16'd10}, 4'hF);
    wr(2'd0, 32'h0000_1000, 4'b0010);       // t=0
    idle(4);
    wr(2'd0, 32'hA500_0000, 4'b1000);       // t=5
    idle(4);
    chk_stat("R9 key outside watchdog, t=9", 32'h0);
    idle(1);
    chk_stat("R9 key outside watchdog ignored", 32'h1);
    clear_flags();
  endtask

  task automatic t_watchdog();
    logic [31:0] v;
    wr(2'd1, {16'd1, 16'd20}, 4'hF);
    wr(2'd0, 32'h0000_9100, 4'b0010);       // t=0
    rd(2'd0, v); chk("R8 ie forced off", v, 32'h0000_9000);
    idle(4);
    wr(2'd0, 32'h5A00_0000, 4'b1000);       // t=5, wrong key
    idle(4);
    wr(2'd0, 32'hA500_0000, 4'b1000);       // t=10, refresh
    idle(19);                                // t=29
    chk("R9 no early reset", {31'b0, wdt_reset}, 32'h0);
    chk_stat("R9 no early expiry", 32'h0);
    idle(1);                                 // t=30
    chk("R10 reset pulse", {31'b0, wdt_reset}, 32'h1);
    chk_stat("R6 watchdog expiry flag", 32'h1);
    chk("R8 irq low in watchdog", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R10 pulse one cycle", {31'b0, wdt_reset}, 32'h0);
    rd(2'd0, v); chk("R10 stopped, watchdog kept", v, 32'h0000_8000);
    clear_flags();
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(2'd0, 32'h0000_9000, 4'b0010);       // start watchdog
    wr(2'd0, 32'h0000_8000, 4'b0010);       // try to clear run only
    rd(2'd0, v); chk("R11 run locked", v, 32'h0000_9000);
    wr(2'd0, 32'h0000_0000, 4'b0010);       // leave watchdog
    rd(2'd0, v); chk("R11 watchdog left", v, 32'h0);
    idle(30);
    chk_stat("R11 no expiry after leaving", 32'h0);
    chk("R11 no reset after leaving", {31'b0, wdt_reset}, 32'h0);
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = 2'd0;
    bus_be    = 4'h0;
    bus_wdata = 32'h0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_oneshot();
    t_continuous();
    t_zero_fields();
    t_key_outside();
    t_watchdog();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule